// File: doc/BRIEF.md
# Debounced Reset Pulse Conditioner

This block takes a raw, active-low reset request from a hot-pluggable module, whose contacts bounce when the module is inserted or removed. It turns that request into one clean, fixed-length, active-high reset pulse for the rest of the clock domain.

The raw line first passes through a flip-flop synchronizer. A Moore state machine then watches the synchronized level and accepts a request only when the level holds steady for a programmed number of clock cycles. On acceptance it drives the output for a programmed number of cycles. It then refuses to fire again until the line has been seen released and steady. A line that bounces, or that stays low for a long time, therefore yields exactly one pulse.

The block's own initialisation reset is asynchronous and active low.

Top module: `bounce_rst_cond`

## Requirements
- R1: While `rst_ni` is low, `pulse_o` is 0, and asserting `rst_ni` clears a pulse in progress at once. After `rst_ni` is released the block is idle, so a request that is still held low is qualified afresh and produces a new pulse.
- R2: `req_ni` passes through SYNC_STAGES (default 2) flip-flops before the state machine uses it. When a qualifying request is first sampled low at rising edge k, `pulse_o` goes high right after edge k+LOW_CYCLES+2.
- R3: A request is accepted only when `req_ni` is sampled low at LOW_CYCLES+1 consecutive rising edges: the first low sample plus LOW_CYCLES more (4 edges with the default LOW_CYCLES=3).
- R4: A high sample during qualification discards the request. Low runs shorter than LOW_CYCLES+1 edges, alone or in bursts, produce no pulse.
- R5: An accepted request drives `pulse_o` high for exactly PULSE_CYCLES (default 2) consecutive cycles. Changes of `req_ni` while the pulse is active neither shorten it nor lengthen it.
- R6: After a pulse, no further pulse can occur until `req_ni` has been sampled high at LOW_CYCLES+1 consecutive edges. A low sample during that release check restarts it. One low level, however long, gives exactly one pulse.
- R7: Once the release has been qualified, a new request that qualifies under R3 produces another pulse with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low initialisation reset |
| req_ni | input | 1 | Raw, possibly bouncing, active-low reset request |
| pulse_o | output | 1 | Registered active-high reset pulse |

## Verification
The request line is driven with single-cycle dips and with low runs one edge short of the qualifying length. Both must stay silent, which separates a counted stability check from a plain edge detector. Runs of exactly the qualifying length and longer runs pin down the acceptance threshold and the start latency. A run that follows isolated dips separates a filter that restarts from one that accumulates low samples. Bounce during the pulse, a low level that returns after a short release, and a clean release followed by a second request tell apart a fixed-width pulse, a qualified release and true re-arming. Resets during a pulse and during a held request show that the block re-enters idle.

// File: rtl/rcond_pkg.sv
package rcond_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_QUAL     = 3'd1,
    ST_FIRE     = 3'd2,
    ST_WAIT_REL = 3'd3,
    ST_REL_QUAL = 3'd4
  } rcond_state_e;
endpackage

// File: rtl/rcond_sync.sv
module rcond_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rcond_ctr.sv
module rcond_ctr #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  assign last_o = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/rcond_fsm.sv
module rcond_fsm
  import rcond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_low_i,
  input  logic qual_last_i,
  input  logic pulse_last_i,
  output logic qual_clr_o,
  output logic qual_inc_o,
  output logic pulse_clr_o,
  output logic pulse_inc_o,
  output logic pulse_o
);
  rcond_state_e state_q, state_d;
  logic         pulse_q;

  always_comb begin
    state_d     = state_q;
    qual_clr_o  = 1'b1;
    qual_inc_o  = 1'b0;
    pulse_clr_o = 1'b1;
    pulse_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_low_i) state_d = ST_QUAL;
      ST_QUAL: begin
        if (!req_low_i)       state_d = ST_IDLE;
        else if (qual_last_i) state_d = ST_FIRE;
        else begin
          qual_clr_o = 1'b0;
          qual_inc_o = 1'b1;
        end
      end
      // request line ignored while firing
      ST_FIRE: begin
        if (pulse_last_i) state_d = ST_WAIT_REL;
        else begin
          pulse_clr_o = 1'b0;
          pulse_inc_o = 1'b1;
        end
      end
      ST_WAIT_REL: if (!req_low_i) state_d = ST_REL_QUAL;
      ST_REL_QUAL: begin
        if (req_low_i)        state_d = ST_WAIT_REL;
        else if (qual_last_i) state_d = ST_IDLE;
        else begin
          qual_clr_o = 1'b0;
          qual_inc_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_d == ST_FIRE);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/bounce_rst_cond.sv
module bounce_rst_cond #(
  parameter int unsigned LOW_CYCLES   = 3,
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic pulse_o
);
  logic req_sync;
  logic req_low;
  logic qual_clr, qual_inc, qual_last;
  logic pulse_clr, pulse_inc, pulse_last;

  // released level on reset so nothing fires from the sync pipeline
  rcond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_ni),
    .q_o   (req_sync)
  );

  assign req_low = ~req_sync;

  rcond_ctr #(.LIMIT(LOW_CYCLES)) qual_ctr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (qual_clr),
    .inc_i (qual_inc),
    .last_o(qual_last)
  );

  rcond_ctr #(.LIMIT(PULSE_CYCLES)) pulse_ctr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pulse_clr),
    .inc_i (pulse_inc),
    .last_o(pulse_last)
  );

  rcond_fsm fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_low_i   (req_low),
    .qual_last_i (qual_last),
    .pulse_last_i(pulse_last),
    .qual_clr_o  (qual_clr),
    .qual_inc_o  (qual_inc),
    .pulse_clr_o (pulse_clr),
    .pulse_inc_o (pulse_inc),
    .pulse_o     (pulse_o)
  );
endmodule

// File: rtl/rcond_chk.sv
module rcond_chk #(
  parameter int unsigned N = 3,
  parameter int unsigned M = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_low_i,
  input logic pulse_i
);
  localparam int unsigned RW = $clog2(N + 2) + 1;
  localparam int unsigned WW = $clog2(M + 1) + 1;
  localparam logic [RW-1:0] RUN_MAX = RW'(N + 1);
  localparam logic [WW-1:0] W_MAX   = WW'(M + 1);

  logic [RW-1:0] lrun_q, hrun_q;
  logic [WW-1:0] wcnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrun_q  <= '0;
      hrun_q  <= '0;
      wcnt_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      lrun_q  <= !req_low_i ? '0 : (lrun_q == RUN_MAX ? lrun_q : lrun_q + RW'(1));
      hrun_q  <=  req_low_i ? '0 : (hrun_q == RUN_MAX ? hrun_q : hrun_q + RW'(1));
      wcnt_q  <= !pulse_i   ? '0 : (wcnt_q == W_MAX   ? wcnt_q : wcnt_q + WW'(1));
      armed_q <= pulse_i ? 1'b0 : ((hrun_q == RUN_MAX) ? 1'b1 : armed_q);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_QUIET: assert (!pulse_i); // R1
  end

  AST_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> (lrun_q == RUN_MAX)); // R3
  AST_WIDTH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> (wcnt_q < WW'(M))); // R5
  AST_WIDTH_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |-> (wcnt_q == WW'(M))); // R5
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> armed_q); // R6
endmodule

bind bounce_rst_cond rcond_chk #(.N(LOW_CYCLES), .M(PULSE_CYCLES)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_low_i(req_low),
  .pulse_i  (pulse_o)
);

// File: tb/bounce_rst_cond_tb_top.sv
module bounce_rst_cond_tb_top;
  localparam int N  = 3;
  localparam int M  = 2;
  localparam int NV = 9;
  localparam int WIN = 41;

  // {pattern (bit c = 1: req low at edge c), expected pulses, expected first start edge}
  localparam logic [27:0] VECS [NV] = '{
    {16'h0001, 4'd0, 8'd0},  // R4 single dip
    {16'h0007, 4'd0, 8'd0},  // R4 one edge short
    {16'h000F, 4'd1, 8'd5},  // R3 exact threshold, R2 latency
    {16'h0077, 4'd0, 8'd0},  // R4 two short bursts
    {16'h00F5, 4'd1, 8'd9},  // R4 dips then run restart
    {16'h00FF, 4'd1, 8'd5},  // R6 long low one pulse
    {16'h3F0F, 4'd1, 8'd5},  // R6 short release ignored
    {16'h005F, 4'd1, 8'd5},  // R5 bounce during pulse
    {16'hF00F, 4'd2, 8'd5}   // R7 clean release then re-fire
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_ni = 1'b1;
  logic pulse_o;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk_i = ~clk_i;

  bounce_rst_cond #(.LOW_CYCLES(N), .PULSE_CYCLES(M)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .pulse_o(pulse_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // count rising edges of pulse_o over a number of cycles, checking widths
  task automatic watch(input int cycles, output int rises, output int bad_w);
    int w;
    bit prev;
    rises = 0; bad_w = 0; w = 0; prev = pulse_o;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (pulse_o && !prev) begin rises++; w = 1; end
      else if (pulse_o) w++;
      else if (prev && w != M) bad_w++;
      prev = pulse_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rises, bad_w;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(pulse_o == 1'b0, "R1", "pulse during reset", pulse_o, 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    check(pulse_o == 1'b0, "R1", "pulse after reset", pulse_o, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] pat;
      int exp_cnt, exp_start, first, w, badw, nr;
      bit prev;
      pat = VECS[v][27:12];
      exp_cnt = int'(VECS[v][11:8]);
      exp_start = int'(VECS[v][7:0]);
      first = -1; w = 0; badw = 0; nr = 0; prev = 1'b0;
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk_i);
        if (c > 0) begin
          if (pulse_o && !prev) begin
            nr++;
            if (first < 0) first = c - 1;
            w = 1;
          end else if (pulse_o) w++;
          else if (prev && w != M) badw++;
          prev = pulse_o;
        end
        req_ni = (c < 16) ? ~pat[c] : 1'b1;
      end
      check(nr == exp_cnt, (exp_cnt == 0) ? "R4" : (exp_cnt == 2) ? "R7" : "R3/R6",
            $sformatf("pulse count vec %0d", v), nr, exp_cnt);
      if (exp_cnt > 0)
        check(first == exp_start, "R2", $sformatf("start edge vec %0d", v), first, exp_start);
      check(badw == 0, "R5", $sformatf("bad widths vec %0d", v), badw, 0);
      repeat (10) @(negedge clk_i);
    end

    // R6 very long low level
    req_ni = 1'b0;
    watch(80, rises, bad_w);
    check(rises == 1, "R6", "pulses on long hold", rises, 1);
    check(bad_w == 0, "R5", "width on long hold", bad_w, 0);
    req_ni = 1'b1;
    repeat (12) @(negedge clk_i);

    // R1 reset during pulse clears it at once
    req_ni = 1'b0;
    for (int c = 0; c < 20 && !pulse_o; c++) @(negedge clk_i);
    check(pulse_o == 1'b1, "R1", "pulse before reset", pulse_o, 1);
    rst_ni = 1'b0;
    #1;
    check(pulse_o == 1'b0, "R1", "pulse cleared by reset", pulse_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // held request re-qualified after reset
    watch(20, rises, bad_w);
    check(rises == 1, "R1", "pulse after reset with held request", rises, 1);
    req_ni = 1'b1;
    repeat (12) @(negedge clk_i);

    // R1 reset during qualification then release: no pulse
    req_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    req_ni = 1'b1;
    rst_ni = 1'b1;
    watch(20, rises, bad_w);
    check(rises == 0, "R1", "no pulse after aborted request", rises, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule